// File: doc/BRIEF.md
# Audio Codec Control Register File

This block is the register file of an audio codec controller on a simple 32-bit word bus. It holds eleven 32-bit slots. Four of them drive codec register transfers: a control word, the codec register address, the outgoing data word and the incoming data word. The other slots form two groups of three, one for the playback DMA channel and one for the capture DMA channel. Each group has a control word whose bit 0 enables the channel, a buffer address and a remaining-byte count. The serial link framing and the DMA data movement live elsewhere. Here the DMA and codec registers are plain storage, and their values are driven onto output ports.

Software starts a codec register transfer by writing the control word with its request bit set. The block then raises a registered one-cycle interrupt. The line it pulses depends on the direction bit in the same write: one line for a request going out, the other for a reply coming back. The request bit never reads back as set.

Top module: `audio_codec_regs`

## Requirements
- R1: While rst_ni is low and after its release, every register reads 0, bus_rdata_o is 0, both interrupt outputs are 0 and all register-derived outputs are 0.
- R2: The register index is bus_addr_i shifted right by two. Address bits [1:0] have no effect on which register is accessed.
- R3: A write stores all 32 bits of bus_wdata_i in the plain registers: index 1 (codec address), 2 (data out), 3 (data in), 5 and 6 (playback address and remaining), 9 and 10 (capture address and remaining). bus_rdata_o carries the addressed register in the cycle after a read strobe and is 0 in a cycle that does not follow a read strobe.
- R4: A write to index 0 with bit 0 = 1 and bit 1 = 1 raises irq_req_sent_o for exactly the one cycle after the write edge, while irq_reply_rdy_o stays 0.
- R5: A write to index 0 with bit 0 = 1 and bit 1 = 0 raises irq_reply_rdy_o for exactly the one cycle after the write edge, while irq_req_sent_o stays 0.
- R6: A write to index 0 with bit 0 = 0 raises neither interrupt. No interrupt rises in a cycle that does not follow a write to index 0.
- R7: Index 0 reads back with bit 0 = 0 and bits 31:1 equal to the last written value. codec_dir_o follows stored bit 1.
- R8: Index 4 (playback control) and index 8 (capture control) store all 32 bits. Their bit 0 drives play_en_o and cap_en_o respectively.
- R9: Index 7 and indices 11 and above read as 0. Writes to them change no register.
- R10: play_addr_o, play_remain_o, cap_addr_o, cap_remain_o, codec_addr_o and codec_wdata_o equal the stored contents of indices 5, 6, 9, 10, 1 and 2. These outputs update in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W (6) | Byte address |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_rd_i | input | 1 | Single-cycle read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle after bus_rd_i |
| irq_req_sent_o | output | 1 | One-cycle pulse: codec request issued |
| irq_reply_rdy_o | output | 1 | One-cycle pulse: codec reply expected |
| codec_dir_o | output | 1 | Stored direction bit of the codec control |
| codec_addr_o | output | 32 | Codec register address |
| codec_wdata_o | output | 32 | Codec data out |
| play_en_o | output | 1 | Playback channel enable |
| play_addr_o | output | 32 | Playback buffer address |
| play_remain_o | output | 32 | Playback remaining count |
| cap_en_o | output | 1 | Capture channel enable |
| cap_addr_o | output | 32 | Capture buffer address |
| cap_remain_o | output | 32 | Capture remaining count |

## Verification
Every result of this block arrives exactly one edge after its strobe. A write shows up on the register outputs and on an interrupt line after the capturing edge, and read data shows up after the edge that samples bus_rd_i. The bench drives strobes on the falling edge for one cycle and samples at the next falling edge, which is the cycle where a result is due. It samples again one cycle later to prove that each interrupt lasts a single cycle and that read data falls back to zero.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 11;

  localparam int IDX_CODEC_CTRL  = 0;
  localparam int IDX_CODEC_ADDR  = 1;
  localparam int IDX_CODEC_DOUT  = 2;
  localparam int IDX_CODEC_DIN   = 3;
  localparam int IDX_PLAY_CTRL   = 4;
  localparam int IDX_PLAY_ADDR   = 5;
  localparam int IDX_PLAY_REMAIN = 6;
  localparam int IDX_RESERVED    = 7;
  localparam int IDX_CAP_CTRL    = 8;
  localparam int IDX_CAP_ADDR    = 9;
  localparam int IDX_CAP_REMAIN  = 10;

  localparam int REQ_BIT = 0;
  localparam int DIR_BIT = 1;
  localparam int EN_BIT  = 0;

  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/acr_decode.sv
module acr_decode
  import acr_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [NUM_REGS-1:0] wr_en_o
);
  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];
  assign idx_o = addr_i[ADDR_W-1:2];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wen
    if (i == IDX_RESERVED) begin : g_rsv
      assign wr_en_o[i] = 1'b0;
    end else begin : g_std
      assign wr_en_o[i] = wr_i && (idx_o == IDX_W'(i));
    end
  end
endmodule

// File: rtl/acr_regfile.sv
module acr_regfile
  import acr_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] wr_en_i,
  input  word_t               wdata_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output word_t               regs_o [NUM_REGS],
  output word_t               rd_mux_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == IDX_RESERVED) begin : g_rsv
      assign regs_o[i] = '0;
    end else begin : g_store
      localparam word_t KEEP = (i == IDX_CODEC_CTRL) ? ~(word_t'(1) << REQ_BIT) : '1;
      word_t q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        q <= '0;
        else if (wr_en_i[i]) q <= wdata_i & KEEP;
      end
      assign regs_o[i] = q;
    end
  end

  always_comb begin
    rd_mux_o = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (rd_idx_i == IDX_W'(k)) rd_mux_o = regs_o[k];
  end

  // R7: request bit never stored
  a_r7_req_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i[IDX_CODEC_CTRL] |=> regs_o[IDX_CODEC_CTRL] == ($past(wdata_i) & ~word_t'(1)));
endmodule

// File: rtl/acr_irq.sv
module acr_irq
  import acr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_wr_i,
  input  logic req_i,
  input  logic dir_i,
  output logic irq_req_sent_o,
  output logic irq_reply_rdy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_req_sent_o  <= 1'b0;
      irq_reply_rdy_o <= 1'b0;
    end else begin
      irq_req_sent_o  <= ctrl_wr_i && req_i && dir_i;
      irq_reply_rdy_o <= ctrl_wr_i && req_i && !dir_i;
    end
  end

  a_r4_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && req_i && dir_i) |=> (irq_req_sent_o && !irq_reply_rdy_o));
  a_r5_reply_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && req_i && !dir_i) |=> (irq_reply_rdy_o && !irq_req_sent_o));
  a_r6_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_wr_i && req_i) |=> !(irq_req_sent_o || irq_reply_rdy_o));
endmodule

// File: rtl/audio_codec_regs.sv
module audio_codec_regs
  import acr_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_req_sent_o,
  output logic              irq_reply_rdy_o,
  output logic              codec_dir_o,
  output logic [31:0]       codec_addr_o,
  output logic [31:0]       codec_wdata_o,
  output logic              play_en_o,
  output logic [31:0]       play_addr_o,
  output logic [31:0]       play_remain_o,
  output logic              cap_en_o,
  output logic [31:0]       cap_addr_o,
  output logic [31:0]       cap_remain_o
);
  logic [IDX_W-1:0]    idx;
  logic [NUM_REGS-1:0] wr_en;
  word_t               regs [NUM_REGS];
  word_t               rd_mux;

  acr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (bus_addr_i),
    .wr_i   (bus_wr_i),
    .idx_o  (idx),
    .wr_en_o(wr_en)
  );

  acr_regfile #(.IDX_W(IDX_W)) u_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .wdata_i (bus_wdata_i),
    .rd_idx_i(idx),
    .regs_o  (regs),
    .rd_mux_o(rd_mux)
  );

  acr_irq u_irq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctrl_wr_i      (wr_en[IDX_CODEC_CTRL]),
    .req_i          (bus_wdata_i[REQ_BIT]),
    .dir_i          (bus_wdata_i[DIR_BIT]),
    .irq_req_sent_o (irq_req_sent_o),
    .irq_reply_rdy_o(irq_reply_rdy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_rdata_o <= '0;
    else         bus_rdata_o <= bus_rd_i ? rd_mux : '0;
  end

  assign codec_dir_o   = regs[IDX_CODEC_CTRL][DIR_BIT];
  assign codec_addr_o  = regs[IDX_CODEC_ADDR];
  assign codec_wdata_o = regs[IDX_CODEC_DOUT];
  assign play_en_o     = regs[IDX_PLAY_CTRL][EN_BIT];
  assign play_addr_o   = regs[IDX_PLAY_ADDR];
  assign play_remain_o = regs[IDX_PLAY_REMAIN];
  assign cap_en_o      = regs[IDX_CAP_CTRL][EN_BIT];
  assign cap_addr_o    = regs[IDX_CAP_ADDR];
  assign cap_remain_o  = regs[IDX_CAP_REMAIN];

  logic unused_din;
  assign unused_din = ^regs[IDX_CODEC_DIN];

  logic hole_idx;
  assign hole_idx = (idx == IDX_W'(IDX_RESERVED)) || (int'(idx) >= NUM_REGS);

  // R9: holes read zero and leave storage untouched
  a_r9_hole_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && hole_idx) |=> bus_rdata_o == '0);
  a_r9_hole_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && hole_idx) |=> ($stable(play_addr_o) && $stable(cap_remain_o) && $stable(codec_addr_o)));
  // R3: no read strobe, no data
  a_r3_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> bus_rdata_o == '0);
  // R10: playback address follows a write to its slot
  a_r10_play_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && idx == IDX_W'(IDX_PLAY_ADDR)) |=> play_addr_o == $past(bus_wdata_i));
  // R8: enable follows bit 0 of a written control word
  a_r8_play_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && idx == IDX_W'(IDX_PLAY_CTRL)) |=> play_en_o == $past(bus_wdata_i[0]));
endmodule

// File: tb/audio_codec_regs_tb.sv
module audio_codec_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_req, irq_rep, dir, p_en, c_en;
  logic [31:0] c_addr, c_wdata, p_addr, p_rem, k_addr, k_rem;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  audio_codec_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_req_sent_o(irq_req),
    .irq_reply_rdy_o(irq_rep), .codec_dir_o(dir), .codec_addr_o(c_addr),
    .codec_wdata_o(c_wdata), .play_en_o(p_en), .play_addr_o(p_addr),
    .play_remain_o(p_rem), .cap_en_o(c_en), .cap_addr_o(k_addr), .cap_remain_o(k_rem)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write strobe for one cycle; returns at the falling edge after the capturing edge
  task automatic bus_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  // {is_write, byte address, data / expected}
  localparam int NV = 20;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 6'h04, 32'hA5A5_0001}, {1'b0, 6'h04, 32'hA5A5_0001}, // R3 codec addr
    {1'b1, 6'h08, 32'h1234_5678}, {1'b0, 6'h08, 32'h1234_5678}, // R3 data out
    {1'b1, 6'h0C, 32'hDEAD_BEEF}, {1'b0, 6'h0C, 32'hDEAD_BEEF}, // R3 data in
    {1'b1, 6'h14, 32'h0000_1000}, {1'b0, 6'h14, 32'h0000_1000}, // R3 play addr
    {1'b1, 6'h18, 32'h0000_0400}, {1'b0, 6'h18, 32'h0000_0400}, // R3 play remain
    {1'b1, 6'h24, 32'h0000_2000}, {1'b0, 6'h24, 32'h0000_2000}, // R3 cap addr
    {1'b1, 6'h28, 32'h0000_0800}, {1'b0, 6'h28, 32'h0000_0800}, // R3 cap remain
    {1'b1, 6'h00, 32'h0000_00F0}, {1'b0, 6'h00, 32'h0000_00F0}, // R7 ctrl, no request
    {1'b1, 6'h10, 32'h0000_0003}, {1'b0, 6'h10, 32'h0000_0003}, // R8 play ctrl
    {1'b1, 6'h20, 32'h0000_0005}, {1'b0, 6'h20, 32'h0000_0005}  // R8 cap ctrl
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", rdata, 32'h0);
    check("R1 irq in reset", {30'h0, irq_req, irq_rep}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", {p_en, c_en, dir} | p_addr | k_rem | c_addr, 32'h0);
    bus_read(6'h18, d); check("R1 play remain reset", d, 32'h0);
    bus_read(6'h00, d); check("R1 ctrl reset", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][38]) begin
        bus_write(VEC[i][37:32], VEC[i][31:0]);
        check("R6 no irq on table write", {30'h0, irq_req, irq_rep}, 32'h0);
      end else begin
        bus_read(VEC[i][37:32], d);
        check($sformatf("R3/R7/R8 table entry %0d", i), d, VEC[i][31:0]);
      end
    end
    @(negedge clk);
    check("R3 rdata zero without read", rdata, 32'h0);

    check("R10 play addr", p_addr, 32'h0000_1000);
    check("R10 play remain", p_rem, 32'h0000_0400);
    check("R10 cap addr", k_addr, 32'h0000_2000);
    check("R10 cap remain", k_rem, 32'h0000_0800);
    check("R10 codec addr", c_addr, 32'hA5A5_0001);
    check("R10 codec wdata", c_wdata, 32'h1234_5678);
    check("R8 enables", {30'h0, p_en, c_en}, 32'h3);

    bus_write(6'h20, 32'h0000_0004);
    check("R8 cap disable", {31'h0, c_en}, 32'h0);

    bus_write(6'h00, 32'h0000_0003);
    check("R4 req pulse", {30'h0, irq_req, irq_rep}, 32'h2);
    @(negedge clk);
    check("R4 req pulse ends", {30'h0, irq_req, irq_rep}, 32'h0);
    check("R7 dir bit", {31'h0, dir}, 32'h1);
    bus_read(6'h00, d); check("R7 ctrl after request", d, 32'h2);

    bus_write(6'h00, 32'h8000_0001);
    check("R5 reply pulse", {30'h0, irq_req, irq_rep}, 32'h1);
    @(negedge clk);
    check("R5 reply pulse ends", {30'h0, irq_req, irq_rep}, 32'h0);
    bus_read(6'h00, d); check("R7 ctrl after reply", d, 32'h8000_0000);

    bus_write(6'h00, 32'h0000_0002);
    check("R6 no pulse without request", {30'h0, irq_req, irq_rep}, 32'h0);

    bus_write(6'h00, 32'h0000_0003);
    bus_write(6'h00, 32'h0000_0003);
    check("R4 back-to-back second pulse", {31'h0, irq_req}, 32'h1);
    @(negedge clk);

    bus_write(6'h07, 32'h0000_0055);
    check("R2 low bits ignored on write", c_addr, 32'h0000_0055);
    bus_read(6'h06, d); check("R2 low bits ignored on read", d, 32'h0000_0055);

    bus_write(6'h1C, 32'hFFFF_FFFF);
    bus_read(6'h1C, d); check("R9 reserved reads zero", d, 32'h0);
    bus_write(6'h2C, 32'hAAAA_AAAA);
    bus_write(6'h3C, 32'h5555_5555);
    check("R9 hole writes ignored", p_addr ^ 32'h1000 | k_rem ^ 32'h800 | c_addr ^ 32'h55, 32'h0);
    bus_read(6'h2C, d); check("R9 index 11 reads zero", d, 32'h0);
    bus_read(6'h3C, d); check("R9 index 15 reads zero", d, 32'h0);
    bus_read(6'h18, d); check("R9 play remain unchanged", d, 32'h0000_0400);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", p_addr | k_addr | c_wdata | {31'h0, p_en}, 32'h0);
    rst_n = 1'b1;
    bus_read(6'h14, d); check("R1 play addr after reset", d, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule